// File: doc/BRIEF.md
# Processor-Side UART Register Front-End

This block is an APB slave that gives a processor a small UART-style register window. It does not shift bits onto a serial line. Its far side is two plain byte streams, each with a valid/ready handshake. A serializer or a loopback model sits behind them. Bytes that arrive on the receive stream are held in a receive FIFO of parameterised depth. The processor drains that FIFO by reading the data port. A processor write to the data port passes one byte to the transmit stream, but only while the transmitter is switched on.

The window decodes five word slots: data, status, control and scaler, plus a reserved fifth slot. The data port has a second address so that byte-wide accesses reach it. Only the low eight address bits are decoded. All transfers finish in their access cycle. A single interrupt line carries one-clock pulses for receive and transmit events. Each kind of event has its own enable in the control word.

Top module: `uart_regfile_front`

## Requirements
- R1: After reset the control word is zero, the receive FIFO is empty, `irq` and `tx_valid` are low, and a status read returns 0x0000_0006.
- R2: A write at offset 0x08 stores all 32 bits of `pwdata` as the control word, and a read at 0x08 returns it. Only `paddr[7:0]` is decoded, so offset 0x108 reaches the same word.
- R3: A read at offset 0x00 or 0x03 returns the oldest stored byte in `prdata[7:0]` with the upper bits zero, and removes that byte. A read of an empty FIFO returns zero and changes nothing.
- R4: While control bit 0 (receive on) is set, `rx_ready` is high exactly when the FIFO holds fewer than DEPTH bytes, and each handshake stores `rx_data`. While bit 0 is clear, `rx_ready` is high and the offered bytes are discarded.
- R5: Status bits: bit 0 is high when the FIFO is non-empty. Bits 1 and 2 are high when no transmit byte is pending. Bit 8 is high when the FIFO holds at least DEPTH/2 bytes. Bit 9 is high when a transmit byte is pending. Bit 10 is high when the FIFO is full. All other bits read zero.
- R6: A write at 0x00 or 0x03 loads `pwdata[7:0]` onto `tx_data` and raises `tx_valid` in the next cycle. This happens only if control bit 1 (transmit on) is set and no byte is pending, or the pending byte is being taken in that cycle. Otherwise the write is dropped. A pending byte is held stable until `tx_ready`.
- R7: `irq` is high for one cycle after a cycle in which a byte was stored with control bit 2 set, or a byte was loaded for transmit with control bit 3 set. If both happen in the same cycle, they give one pulse.
- R8: Writes to offsets 0x04, 0x0C and any unmapped offset change nothing. Reads of 0x0C and of unmapped offsets return zero.
- R9: `pready` is always high and `pslverr` is always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| pslverr | output | 1 | APB error, tied low |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Block accepts the offered byte |
| tx_data | output | 8 | Byte to transmit |
| tx_valid | output | 1 | Transmit byte pending |
| tx_ready | input | 1 | Downstream takes the pending byte |
| irq | output | 1 | Interrupt pulse |

## Verification
Two pairs of events can land in the same clock.

- **Receive store with data-port pop.** A receive byte can be stored in the same cycle that a data-port read pops the FIFO. The bench keeps the receive stream offering bytes while it issues back-to-back data reads, both on a full FIFO and on a partly filled one. Its queue model then confirms the order of the bytes and the fill level.
- **Receive store with transmit load.** A receive store can coincide with a transmit load while both interrupt enables are set. The bench writes the data port while receive bytes are streaming, and checks that `irq` shows exactly the model's single pulse.

// File: rtl/uart_regfile_front.sv
module uart_regfile_front #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_N = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_N = CW'(DEPTH / 2);
  localparam logic [PW-1:0] LAST_P = PW'(DEPTH - 1);

  logic [31:0]   ctrl_q;
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic [7:0]    off;
  logic          access, sel_data, push, pop, tx_load, rx_full, rx_half;
  logic [31:0]   status;
  logic [ADDR_W-9:0] unused_addr_hi;

  assign unused_addr_hi = paddr[ADDR_W-1:8];
  assign off      = paddr[7:0];
  assign access   = psel & penable;
  assign sel_data = (off == 8'h00) || (off == 8'h03);
  assign rx_full  = (count == FULL_N);
  assign rx_half  = (count >= HALF_N);
  assign rx_ready = !ctrl_q[0] || !rx_full;
  assign push     = rx_valid && rx_ready && ctrl_q[0];
  assign pop      = access && !pwrite && sel_data && (count != '0);
  assign tx_load  = access && pwrite && sel_data && ctrl_q[1] && (!tx_valid || tx_ready);
  assign pready   = 1'b1;
  assign pslverr  = 1'b0;

  assign status = {21'd0, rx_full, tx_valid, rx_half, 1'b0, 4'd0,
                   !tx_valid, !tx_valid, count != '0};

  always_comb begin
    prdata = '0;
    if (sel_data) prdata = (count != '0) ? {24'd0, mem[rd_ptr]} : 32'd0;
    else if (off == 8'h04) prdata = status;
    else if (off == 8'h08) prdata = ctrl_q;
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
      irq      <= 1'b0;
    end else begin
      if (access && pwrite && off == 8'h08) ctrl_q <= pwdata;
      if (push) wr_ptr <= (wr_ptr == LAST_P) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST_P) ? '0 : rd_ptr + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
      if (tx_load) begin
        tx_valid <= 1'b1;
        tx_data  <= pwdata[7:0];
      end else if (tx_ready) begin
        tx_valid <= 1'b0;
      end
      irq <= (push && ctrl_q[2]) || (tx_load && ctrl_q[3]);
    end
  end
endmodule

// File: rtl/uart_regfile_front_chk.sv
module uart_regfile_front_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic          pready,
  input logic          pslverr,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic          rx_en,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          irq,
  input logic [CW-1:0] count
);
  assert_apb_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pready && !pslverr);
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_full_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && count == CW'(DEPTH)) |-> !rx_ready);
  assert_off_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> rx_ready);
  assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past((rx_valid && rx_ready) || (psel && penable && pwrite)));
endmodule

bind uart_regfile_front uart_regfile_front_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .pready(pready), .pslverr(pslverr), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_en(ctrl_q[0]), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .irq(irq), .count(count)
);

// File: tb/uart_regfile_front_bench.sv
module uart_regfile_front_bench;
  localparam int DEPTH = 16;

  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic pready, pslverr;
  logic [7:0] rx_data = 8'h10;
  logic rx_valid = 0, rx_ready;
  logic [7:0] tx_data;
  logic tx_valid, tx_ready = 0, irq;

  int checks = 0, fails = 0;
  bit done = 0, rx_on = 0;
  string tag_override = "";

  always #10 clk = ~clk;

  uart_regfile_front #(.DEPTH(DEPTH), .ADDR_W(12)) u_uart_regfile_front (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .irq(irq)
  );

  logic [7:0]  q[$];
  logic [31:0] m_ctrl = '0;
  bit          m_txv = 0, m_irq = 0;
  logic [7:0]  m_txd = '0;

  function automatic bit m_rdy();
    return !m_ctrl[0] || (q.size() < DEPTH);
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] o);
    logic [31:0] s;
    s = '0;
    s[0] = q.size() > 0;
    s[1] = !m_txv;
    s[2] = !m_txv;
    s[8] = q.size() >= DEPTH / 2;
    s[9] = m_txv;
    s[10] = q.size() == DEPTH;
    if (o == 8'h00 || o == 8'h03) return (q.size() > 0) ? {24'd0, q[0]} : 32'd0;
    if (o == 8'h04) return s;
    if (o == 8'h08) return m_ctrl;
    return 32'd0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_ctrl = '0; m_txv = 0; m_irq = 0; m_txd = '0;
    end else begin
      bit acc, dsel, push, pop, ld;
      acc  = psel && penable;
      dsel = paddr[7:0] == 8'h00 || paddr[7:0] == 8'h03;
      push = rx_valid && m_rdy() && m_ctrl[0];
      pop  = acc && !pwrite && dsel && q.size() > 0;
      ld   = acc && pwrite && dsel && m_ctrl[1] && (!m_txv || tx_ready);
      m_irq = (push && m_ctrl[2]) || (ld && m_ctrl[3]);
      if (pop) void'(q.pop_front());
      if (push) q.push_back(rx_data);
      if (ld) begin m_txv = 1; m_txd = pwdata[7:0]; end
      else if (tx_ready) m_txv = 0;
      if (acc && pwrite && paddr[7:0] == 8'h08) m_ctrl = pwdata;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rx_ready == m_rdy(), "R4", "rx_ready", 32'(rx_ready), 32'(m_rdy()));
      chk(tx_valid == m_txv, "R6", "tx_valid", 32'(tx_valid), 32'(m_txv));
      if (m_txv) chk(tx_data == m_txd, "R6", "tx_data", 32'(tx_data), 32'(m_txd));
      chk(irq == m_irq, "R7", "irq", 32'(irq), 32'(m_irq));
      chk(pready && !pslverr, "R9", "pready/pslverr", {30'd0, pready, pslverr}, 32'h2);
      if (psel && penable && !pwrite) begin
        string t;
        logic [7:0] o;
        o = paddr[7:0];
        t = (o == 8'h00 || o == 8'h03) ? "R3" : (o == 8'h04) ? "R5" :
            (o == 8'h08) ? "R2" : "R8";
        if (tag_override != "") t = tag_override;
        chk(prdata == m_read(o), t, "prdata", prdata, m_read(o));
      end
    end
  end

  initial begin
    bit hs;
    forever begin
      @(negedge clk);
      hs = rx_valid && rx_ready;
      @(posedge clk);
      #1;
      if (hs) rx_data = rx_data + 8'd1;
      rx_valid = rx_on;
    end
  end

  task automatic apb(input bit wr, input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
    @(posedge clk); #2;
    penable = 1;
    @(posedge clk); #2;
    psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!irq && !tx_valid && rx_ready, "R1", "outputs after reset",
        {29'd0, irq, tx_valid, rx_ready}, 32'h1);
    tag_override = "R1";
    apb(0, 12'h004, 0);
    apb(0, 12'h008, 0);
    tag_override = "";
    apb(0, 12'h000, 0);
    // R4: receive off, bytes are discarded
    rx_on = 1; idle(4); rx_on = 0; idle(2);
    apb(0, 12'h004, 0);
    apb(0, 12'h000, 0);
    // R4/R5: fill to full with receive interrupt
    apb(1, 12'h008, 32'h5);
    rx_on = 1; idle(DEPTH + 6);
    apb(0, 12'h004, 0);
    // R3: pops through both aliases while bytes keep arriving
    for (int i = 0; i < 20; i++) apb(0, (i % 2) ? 12'h003 : 12'h000, 0);
    rx_on = 0;
    for (int i = 0; i < DEPTH + 3; i++) apb(0, 12'h000, 0);
    apb(0, 12'h004, 0);
    // R6/R7: transmit with stall, drop and release
    apb(1, 12'h008, 32'hF);
    tx_ready = 0;
    apb(1, 12'h000, 32'h1A5);
    apb(0, 12'h004, 0);
    apb(1, 12'h003, 32'h5A);
    tx_ready = 1; idle(2);
    // R7: receive store and transmit load in one cycle
    rx_on = 1;
    apb(1, 12'h000, 32'h33);
    apb(1, 12'h003, 32'h44);
    rx_on = 0; idle(2);
    // R8: ignored writes and zero reads
    apb(1, 12'h004, 32'hFFFF_FFFF);
    apb(1, 12'h00C, 32'hFFFF_FFFF);
    apb(1, 12'h010, 32'hFFFF_FFFF);
    apb(0, 12'h004, 0);
    apb(0, 12'h008, 0);
    apb(0, 12'h00C, 0);
    apb(0, 12'h010, 0);
    apb(0, 12'h040, 0);
    // R2: upper address bits ignored
    apb(1, 12'h108, 32'h8000_0007);
    apb(0, 12'h008, 0);
    apb(0, 12'h208, 0);
    // mixed random traffic
    for (int i = 0; i < 600; i++) begin
      logic [11:0] a;
      int k;
      k = int'($urandom % 9);
      case (k)
        0: a = 12'h000; 1: a = 12'h003; 2: a = 12'h004; 3: a = 12'h008;
        4: a = 12'h00C; 5: a = 12'h010; 6: a = 12'h103; 7: a = 12'h100;
        default: a = 12'h000;
      endcase
      rx_on = ($urandom % 3) != 0;
      tx_ready = ($urandom % 2) != 0;
      if (a[7:0] == 8'h08 && ($urandom % 4) == 0)
        apb(1, a, $urandom | 32'h3);
      else
        apb(($urandom % 2) != 0, a, $urandom);
    end
    rx_on = 0; tx_ready = 1; idle(3);
    done = 1;
    summary();
    $finish;
  end
endmodule